// File: doc/BRIEF.md
# Settable Minutes-Seconds Clock Controller

This block keeps time for a four-digit minutes:seconds display and lets the user adjust it. It runs on one fast system clock. A free-running divider makes a one-second tick that advances the time and a faster sampling tick that an upstream debouncer can use. The four BCD digits are seconds units (modulo 10), seconds tens (modulo 6), minutes units (modulo 10) and minutes tens (modulo 6). Each digit carries into the next one, so the display wraps from 59:59 to 00:00.

Four key strobes arrive already debounced. Each is an active-low pulse lasting one clock. The set key switches between running and setting. While setting, time stands still. The position key rotates a digit selector, and the add key steps only the selected digit within that digit's own range. A clear key zeroes all four digits. In setting mode the selected digit blinks: its segment pattern is replaced by blank on alternate half-seconds. Every digit has its own active-low seven-segment pattern output. Display multiplexing is left to the circuit downstream.

Top module: `mmss_clock`

## Requirements
- R1: `tick_1hz` is high for exactly one clock in every SEC_DIV = CLK_HZ/TICK_HZ clocks. The first pulse comes in the SEC_DIV-th clock after reset is released.
- R2: `tick_100hz` is high for exactly one clock in every SMP_DIV = CLK_HZ/SAMPLE_HZ clocks. The first pulse comes in the SMP_DIV-th clock after reset is released.
- R3: Seconds units (`bcd[3:0]`) advance on each one-second tick while running. They wrap from 9 to 0, and that wrap advances seconds tens.
- R4: Seconds tens (`bcd[7:4]`) wrap from 5 to 0 and carry into minutes units (`bcd[11:8]`, 9 to 0). Minutes units carry into minutes tens (`bcd[15:12]`, 5 to 0), so 59:59 is followed by 00:00.
- R5: Each low pulse on `key_set_n` toggles `setting`. The first press after reset enters setting mode.
- R6: Each low pulse on `key_pos_n` advances a selector through 0, 1, 2, 3 and back to 0. Digit 0 is seconds units and digit 3 is minutes tens. `dig_sel_n` is 1110, 1101, 1011 and 0111 for selector values 0 to 3.
- R7: While `setting` is high, ticks change no digit and no carry propagates.
- R8: While setting, an add pulse increments only the selected digit and wraps it at its own modulus: 9 to 0 for units digits, 5 to 0 for tens digits. While running, an add pulse changes nothing.
- R9: A low pulse on `key_clr_n` zeroes all four digits at the next edge. It takes priority over ticks and add.
- R10: The segment output for digit i, `seg_n[7i+6:7i]`, is active low with segment a in the MSB and segment g in the LSB. The patterns for 0 to 9 are 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000 and 0000100.
- R11: A blink phase starts low at reset and toggles every SEC_DIV/2 clocks. While setting and the phase is high, the selected digit's segments are 1111111. All other segment outputs show their normal pattern.
- R12: An active-low `rst_n` zeroes the digits, the selector, the mode, both dividers and the blink phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_set_n | input | 1 | Set/run toggle strobe, active low, one clock |
| key_pos_n | input | 1 | Digit selector advance strobe, active low |
| key_add_n | input | 1 | Increment selected digit strobe, active low |
| key_clr_n | input | 1 | Zero all digits strobe, active low |
| tick_1hz | output | 1 | One-clock pulse per second |
| tick_100hz | output | 1 | One-clock key sampling pulse |
| setting | output | 1 | High in setting mode |
| bcd | output | 16 | Four BCD digits, seconds units in the low nibble |
| dig_sel_n | output | 4 | Active-low one-hot selected digit |
| seg_n | output | 28 | Four active-low 7-segment patterns, digit i in bits 7i+6:7i |

## Verification
Digits, mode and selector are registered, so a key strobe or tick seen at one rising edge is visible at the following falling edge, one clock later. The tick pulses and the segment patterns are combinational from registered state, so they are due in the same cycle as the state that produces them. The reference model applies each sampled key at the rising edge in the same order the requirements give: clear first, then add or carry using the old mode, then mode and selector. Every output is compared at each falling edge, and directed checks read the time after each group of key presses.

// File: rtl/mmss_clock.sv
module mmss_clock #(
  parameter int CLK_HZ    = 20_000_000,
  parameter int TICK_HZ   = 1,
  parameter int SAMPLE_HZ = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_set_n,
  input  logic        key_pos_n,
  input  logic        key_add_n,
  input  logic        key_clr_n,
  output logic        tick_1hz,
  output logic        tick_100hz,
  output logic        setting,
  output logic [15:0] bcd,
  output logic [3:0]  dig_sel_n,
  output logic [27:0] seg_n
);

  localparam int SEC_DIV  = CLK_HZ / TICK_HZ;
  localparam int HALF_DIV = SEC_DIV / 2;
  localparam int SMP_DIV  = CLK_HZ / SAMPLE_HZ;
  localparam int SW = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
  localparam int PW = (SMP_DIV > 1) ? $clog2(SMP_DIV) : 1;

  logic [SW-1:0] sec_cnt;
  logic [PW-1:0] smp_cnt;
  logic          phase_q;
  logic [1:0]    sel_q;
  logic [3:0]    dig_q [4];
  logic [4:0]    step;

  assign tick_1hz   = (sec_cnt == SW'(SEC_DIV - 1));
  assign tick_100hz = (smp_cnt == PW'(SMP_DIV - 1));
  assign dig_sel_n  = ~(4'b0001 << sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
      smp_cnt <= '0;
      phase_q <= 1'b0;
    end else begin
      sec_cnt <= tick_1hz ? '0 : sec_cnt + 1'b1;
      smp_cnt <= tick_100hz ? '0 : smp_cnt + 1'b1;
      if (tick_1hz || sec_cnt == SW'(HALF_DIV - 1)) phase_q <= ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting <= 1'b0;
      sel_q   <= 2'd0;
    end else begin
      if (!key_set_n) setting <= ~setting;
      if (!key_pos_n) sel_q <= sel_q + 2'd1;
    end
  end

  assign step[0] = tick_1hz && !setting;

  function automatic logic [6:0] seg_of(input logic [3:0] v);
    case (v)
      4'd0: seg_of = 7'b0000001;
      4'd1: seg_of = 7'b1001111;
      4'd2: seg_of = 7'b0010010;
      4'd3: seg_of = 7'b0000110;
      4'd4: seg_of = 7'b1001100;
      4'd5: seg_of = 7'b0100100;
      4'd6: seg_of = 7'b0100000;
      4'd7: seg_of = 7'b0001111;
      4'd8: seg_of = 7'b0000000;
      4'd9: seg_of = 7'b0000100;
      default: seg_of = 7'b1111111;
    endcase
  endfunction

  for (genvar i = 0; i < 4; i++) begin : g_dig
    localparam logic [3:0] TOP = (i % 2 == 0) ? 4'd9 : 4'd5;
    logic at_top, bump;
    assign at_top     = (dig_q[i] == TOP);
    assign step[i+1]  = step[i] && at_top;
    assign bump       = step[i] || (setting && !key_add_n && sel_q == 2'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dig_q[i] <= 4'd0;
      else if (!key_clr_n) dig_q[i] <= 4'd0;
      else if (bump)       dig_q[i] <= at_top ? 4'd0 : dig_q[i] + 4'd1;
    end

    assign bcd[4*i +: 4] = dig_q[i];
    assign seg_n[7*i +: 7] = (setting && phase_q && sel_q == 2'(i)) ? 7'b1111111
                                                                     : seg_of(dig_q[i]);

    assert_digit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dig_q[i] <= TOP);
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_sel_n) == 1);
  assert_mode_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !key_set_n |=> setting != $past(setting));
  assert_hold_in_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (setting && key_add_n && key_clr_n) |=> $stable(bcd));
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_clr_n |=> bcd == 16'h0000);
  assert_seg_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !setting |-> seg_n[6:0] != 7'b1111111);

endmodule

// File: tb/mmss_clock_tb.sv
module mmss_clock_tb_top;
  localparam int CLK_HZ = 40, TICK_HZ = 1, SAMPLE_HZ = 10;
  localparam int SEC_DIV = CLK_HZ / TICK_HZ, HALF_DIV = SEC_DIV / 2;
  localparam int SMP_DIV = CLK_HZ / SAMPLE_HZ;

  logic clk = 0, rst_n = 0;
  logic key_set_n = 1, key_pos_n = 1, key_add_n = 1, key_clr_n = 1;
  logic tick_1hz, tick_100hz, setting;
  logic [15:0] bcd;
  logic [3:0] dig_sel_n;
  logic [27:0] seg_n;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mmss_clock #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .SAMPLE_HZ(SAMPLE_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_set_n(key_set_n), .key_pos_n(key_pos_n),
    .key_add_n(key_add_n), .key_clr_n(key_clr_n), .tick_1hz(tick_1hz),
    .tick_100hz(tick_100hz), .setting(setting), .bcd(bcd),
    .dig_sel_n(dig_sel_n), .seg_n(seg_n));

  int m_cnt, m_scnt, m_ph, m_mode, m_sel;
  int m_d [4];

  function automatic int lim(input int i); return (i % 2 == 0) ? 10 : 6; endfunction

  function automatic logic [6:0] pat(input int v);
    case (v)
      0: return 7'b0000001; 1: return 7'b1001111; 2: return 7'b0010010;
      3: return 7'b0000110; 4: return 7'b1001100; 5: return 7'b0100100;
      6: return 7'b0100000; 7: return 7'b0001111; 8: return 7'b0000000;
      default: return 7'b0000100;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_scnt = 0; m_ph = 0; m_mode = 0; m_sel = 0;
      for (int i = 0; i < 4; i++) m_d[i] = 0;
    end else begin
      bit t;
      t = (m_cnt == SEC_DIV - 1);
      if (m_cnt == HALF_DIV - 1 || t) m_ph = 1 - m_ph;
      m_cnt = (m_cnt + 1) % SEC_DIV;
      m_scnt = (m_scnt + 1) % SMP_DIV;
      if (!key_clr_n) begin
        for (int i = 0; i < 4; i++) m_d[i] = 0;
      end else if (m_mode == 1) begin
        if (!key_add_n) m_d[m_sel] = (m_d[m_sel] + 1) % lim(m_sel);
      end else if (t) begin
        for (int i = 0; i < 4; i++) begin
          m_d[i] = (m_d[i] + 1) % lim(i);
          if (m_d[i] != 0) break;
        end
      end
      if (!key_set_n) m_mode = 1 - m_mode;
      if (!key_pos_n) m_sel = (m_sel + 1) % 4;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 tick_1hz", tick_1hz, m_cnt == SEC_DIV - 1);
    chk("R2 tick_100hz", tick_100hz, m_scnt == SMP_DIV - 1);
    chk("R3 seconds units", bcd[3:0], m_d[0]);
    chk("R4 upper digits", bcd[15:4], {m_d[3][3:0], m_d[2][3:0], m_d[1][3:0]});
    chk("R5 setting", setting, m_mode);
    chk("R6 dig_sel_n", dig_sel_n, ~(4'b1 << m_sel) & 4'hF);
    for (int i = 0; i < 4; i++) begin
      if (m_mode == 1 && m_ph == 1 && m_sel == i)
        chk("R11 blank", seg_n[7*i +: 7], 7'h7F);
      else
        chk("R10 segments", seg_n[7*i +: 7], pat(m_d[i]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int k, input int n);
    repeat (n) begin
      @(negedge clk);
      case (k)
        0: key_set_n = 0; 1: key_pos_n = 0; 2: key_add_n = 0; default: key_clr_n = 0;
      endcase
      @(negedge clk);
      key_set_n = 1; key_pos_n = 1; key_add_n = 1; key_clr_n = 1;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(5); rst_n = 1;
    cyc(1);
    chk("R12 reset digits", bcd, 16'h0000);
    chk("R12 reset selector", dig_sel_n, 4'b1110);
    chk("R12 reset mode", setting, 0);
    cyc(300);
    press(0, 1);
    press(3, 1);
    chk("R9 clear", bcd, 16'h0000);
    press(2, 12);
    chk("R8 units wrap", bcd, 16'h0002);
    press(1, 1); press(2, 7);
    chk("R8 tens wrap", bcd, 16'h0012);
    press(1, 1); press(2, 9);
    chk("R8 min units", bcd, 16'h0912);
    press(1, 1); press(2, 5);
    chk("R8 min tens", bcd, 16'h5912);
    press(1, 1);
    chk("R6 selector back to 0", dig_sel_n, 4'b1110);
    cyc(100);
    chk("R7 hold while setting", bcd, 16'h5912);
    press(0, 1);
    press(2, 3);
    chk("R8 add ignored when running", bcd, 16'h5912);
    cyc(2000);
    chk("R4 wrap past 59:59", bcd[15:8], 8'h00);
    press(0, 1); press(1, 2); cyc(45);
    @(negedge clk); key_clr_n = 0; key_set_n = 0;
    @(negedge clk); key_clr_n = 1; key_set_n = 1;
    chk("R9 clear with set", bcd, 16'h0000);
    chk("R5 exit with clear", setting, 0);
    cyc(137);
    @(negedge clk); rst_n = 0;
    cyc(3); rst_n = 1;
    cyc(1);
    chk("R12 mid reset", {bcd, dig_sel_n}, {16'h0000, 4'b1110});
    cyc(200);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule